// File: doc/BRIEF.md
# Log-Domain Check Node Processor

This block is the check-node stage of a sum-product decoder for low-density parity-check codes. It works in the log-likelihood domain. Each cycle it can take one row of `DEG` signed input messages. For every edge of that row it returns the extrinsic message, which is formed from the other `DEG-1` inputs only. The unit is a fixed-latency pipeline and takes a new row on every clock. A surrounding decoder can therefore stream rows through it without stalls.

Each input is an `IN_W`-bit two's complement value with two fractional bits. Its magnitude is clipped to a 6-bit index. The index goes through a transform table for phi(x) = ln((e^x+1)/(e^x-1)), and the table's content is fixed in the design. An adder tree sums the transformed values of the whole row. Each edge then subtracts its own term, clips the result to the table range, and passes it through the same table again. The sign of the result is the product of the signs of the other inputs. The per-edge exclusion uses one total sum and one total sign, so the row is summed only once and is not summed again for each edge.

Top module: `logbp_check_node`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_msg` is all zeros. `out_valid` equals `in_valid` delayed by exactly 3 clock cycles. A row accepted on one rising edge appears at the outputs after the third rising edge from it.
- R2: Lane k of `in_llr` is bits [k*IN_W +: IN_W], in two's complement. Its magnitude is clipped to 63 before the table lookup, and the value -128 also gives 63. No output lane is ever outside -63..+63.
- R3: The table T maps a 6-bit index to a 6-bit value: T(0)=63, T(1)=8, T(2)=6, T(3)=4, T(4)=3, T(5)=2, T(6)=2, T(7..11)=1, T(12..63)=0. These are round(4*phi(i/4)), clipped to 63. Output magnitude of lane k = T(min(63, S - T(m_k))), where m_k is the clipped magnitude of lane k and S is the sum of T(m_j) over all lanes.
- R4: An input is negative when its value is below zero. Zero counts as positive. Output lane k is negative when an odd number of the other lanes are negative. A zero magnitude is always output as 0.
- R5: When the excluded sum S - T(m_k) exceeds 63, the index saturates at 63 and output lane k is 0.
- R6: A new row can be accepted on every cycle, including directly after a cycle with `in_valid` low. Results leave in the order the rows arrived.
- R7: `in_llr` is ignored while `in_valid` is low. During such cycles and their results, `out_valid` stays low and `out_msg` keeps the last valid result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies `in_llr` for this cycle |
| in_llr | input | DEG*IN_W | Input messages, lane k at bits [k*IN_W +: IN_W] |
| out_valid | output | 1 | Qualifies `out_msg` |
| out_msg | output | DEG*IN_W | Extrinsic messages, same lane layout |

## Verification
Two things can happen in the same cycle. The input stage can capture a new row while the output stage is emitting the result of a row taken three cycles earlier. These two events can also coincide with an idle gap in the stream. The bench provokes this by streaming table-driven and random rows back to back. It also inserts a cycle with `in_valid` low whose data is garbage. Each output is judged at its own latency against a model that computes phi with real arithmetic. The cycle that corresponds to the gap must show `out_valid` low with the previous result held.

// File: rtl/logbp_cn_pkg.sv
package logbp_cn_pkg;

  // Table index width and table output width.
  localparam int MAG_W   = 6;
  localparam int PHI_MAX = (1 << MAG_W) - 1;

  // Transform table: round(4*phi(i/4)) for index i, with index 0 clipped to the top value.
  function automatic logic [MAG_W-1:0] phi_lut(input logic [MAG_W-1:0] idx);
    logic [MAG_W-1:0] r;
    case (idx)
      6'd0:    r = 6'd63;
      6'd1:    r = 6'd8;
      6'd2:    r = 6'd6;
      6'd3:    r = 6'd4;
      6'd4:    r = 6'd3;
      6'd5,
      6'd6:    r = 6'd2;
      6'd7,
      6'd8,
      6'd9,
      6'd10,
      6'd11:   r = 6'd1;
      default: r = 6'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cn_edge_front.sv
module cn_edge_front
  import logbp_cn_pkg::*;
#(
  parameter int IN_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic signed [IN_W-1:0] llr,
  output logic [MAG_W-1:0]       phi_q,
  output logic                   sgn_q
);
  logic             neg;
  logic [IN_W-1:0]  abs_v;
  logic [MAG_W-1:0] mag;

  always_comb begin
    neg   = llr[IN_W-1];
    abs_v = neg ? $unsigned(-llr) : $unsigned(llr);
    mag   = (abs_v > IN_W'(PHI_MAX)) ? MAG_W'(PHI_MAX) : abs_v[MAG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phi_q <= '0;
      sgn_q <= 1'b0;
    end else if (en) begin
      phi_q <= phi_lut(mag);
      sgn_q <= neg;
    end
  end
endmodule

// File: rtl/cn_sum_tree.sv
module cn_sum_tree
  import logbp_cn_pkg::*;
#(
  parameter int DEG   = 4,
  parameter int SUM_W = 8
) (
  input  logic [DEG-1:0][MAG_W-1:0] terms,
  output logic [SUM_W-1:0]          total
);
  localparam int LVL  = (DEG > 1) ? $clog2(DEG) : 1;
  localparam int NPAD = 1 << LVL;

  // Pairwise reduction, halving the width at each level.
  always_comb begin
    logic [SUM_W-1:0] acc [NPAD];
    for (int i = 0; i < NPAD; i++)
      acc[i] = (i < DEG) ? SUM_W'(terms[i]) : '0;
    for (int w = NPAD / 2; w >= 1; w = w / 2)
      for (int i = 0; i < w; i++)
        acc[i] = acc[2*i] + acc[2*i+1];
    total = acc[0];
  end
endmodule

// File: rtl/cn_edge_back.sv
module cn_edge_back
  import logbp_cn_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int SUM_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic [SUM_W-1:0]       total,
  input  logic                   total_sgn,
  input  logic [MAG_W-1:0]       own_phi,
  input  logic                   own_sgn,
  output logic                   excl_over,
  output logic signed [IN_W-1:0] msg_q
);
  logic [SUM_W-1:0]       excl;
  logic [MAG_W-1:0]       idx;
  logic [MAG_W-1:0]       mag;
  logic signed [IN_W-1:0] mag_s;
  logic                   neg;

  always_comb begin
    excl      = total - SUM_W'(own_phi);
    excl_over = excl > SUM_W'(PHI_MAX);
    idx       = excl_over ? MAG_W'(PHI_MAX) : excl[MAG_W-1:0];
    mag       = phi_lut(idx);
    mag_s     = $signed({{(IN_W-MAG_W){1'b0}}, mag});
    neg       = total_sgn ^ own_sgn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  msg_q <= '0;
    else if (en) msg_q <= neg ? -mag_s : mag_s;
  end
endmodule

// File: rtl/logbp_check_node.sv
module logbp_check_node
  import logbp_cn_pkg::*;
#(
  parameter int DEG  = 4,
  parameter int IN_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [DEG*IN_W-1:0] in_llr,
  output logic                out_valid,
  output logic [DEG*IN_W-1:0] out_msg
);
  localparam int SUM_W = MAG_W + $clog2(DEG);

  logic                      v1, v2;
  logic [DEG-1:0][MAG_W-1:0] phi1, phi2;
  logic [DEG-1:0]            sgn1, sgn2;
  logic [SUM_W-1:0]          total1, total2;
  logic                      tsgn2;
  logic [DEG-1:0]            excl_over;

  // Stage 1: clip, look up and capture sign per edge.
  for (genvar k = 0; k < DEG; k++) begin : g_front
    cn_edge_front #(.IN_W(IN_W)) u_front (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (in_valid),
      .llr   ($signed(in_llr[k*IN_W +: IN_W])),
      .phi_q (phi1[k]),
      .sgn_q (sgn1[k])
    );
  end

  cn_sum_tree #(.DEG(DEG), .SUM_W(SUM_W)) u_tree (
    .terms (phi1),
    .total (total1)
  );

  // Stage 2: row total, row sign and per-edge terms.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total2 <= '0;
      tsgn2  <= 1'b0;
      phi2   <= '0;
      sgn2   <= '0;
    end else if (v1) begin
      total2 <= total1;
      tsgn2  <= ^sgn1;
      phi2   <= phi1;
      sgn2   <= sgn1;
    end
  end

  // Stage 3: exclude own term, second lookup, apply sign.
  for (genvar k = 0; k < DEG; k++) begin : g_back
    logic signed [IN_W-1:0] msg;
    cn_edge_back #(.IN_W(IN_W), .SUM_W(SUM_W)) u_back (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (v2),
      .total     (total2),
      .total_sgn (tsgn2),
      .own_phi   (phi2[k]),
      .own_sgn   (sgn2[k]),
      .excl_over (excl_over[k]),
      .msg_q     (msg)
    );
    assign out_msg[k*IN_W +: IN_W] = msg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1        <= 1'b0;
      v2        <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      v1        <= in_valid;
      v2        <= v1;
      out_valid <= v2;
    end
  end
endmodule

// File: rtl/logbp_cn_chk.sv
module logbp_cn_chk #(
  parameter int DEG  = 4,
  parameter int IN_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                out_valid,
  input logic [DEG*IN_W-1:0] out_msg,
  input logic                v2,
  input logic [DEG-1:0]      excl_over
);
  logic [1:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             since <= '0;
    else if (since != 2'd3) since <= since + 2'd1;
  end

  p_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((since != 2'd0) && !out_valid) |-> $stable(out_msg));

  for (genvar k = 0; k < DEG; k++) begin : g_lane
    p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($signed(out_msg[k*IN_W +: IN_W]) >= -63 &&
                     $signed(out_msg[k*IN_W +: IN_W]) <= 63));

    p_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (v2 && excl_over[k]) |=> (out_msg[k*IN_W +: IN_W] == '0));
  end
endmodule

bind logbp_check_node logbp_cn_chk #(.DEG(DEG), .IN_W(IN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_msg   (out_msg),
  .v2        (v2),
  .excl_over (excl_over)
);

// File: tb/test_logbp_check_node.sv
`timescale 1ns/1ps
module test_logbp_check_node;
  localparam int DEG  = 4;
  localparam int W    = 8;
  localparam int NTAB = 8;
  localparam int NRND = 24;
  localparam int NALL = NTAB + NRND;

  typedef logic [DEG*W-1:0] vec_t;

  // Stimulus and hand-worked expected rows (lane 0 in the low byte).
  localparam vec_t STIM [NTAB] = '{
    32'h04040404, 32'hF803FE01, 32'h02FF0500, 32'h3228E214,
    32'hF40C0C02, 32'hC0037F80, 32'h0C070605, 32'h0B0A09FF };
  localparam vec_t EXPV [NTAB] = '{
    32'h01010101, 32'h00000001, 32'h00000000, 32'hC1C13FC1,
    32'h02FEFEC1, 32'hFD3F03FD, 32'h02030404, 32'hFFFFFF04 };

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  vec_t in_llr;
  logic out_valid;
  vec_t out_msg;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  vec_t sv [NALL];
  vec_t ev [NALL];

  always #4 clk = ~clk;

  logbp_check_node #(.DEG(DEG), .IN_W(W)) i_logbp_check_node (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_llr(in_llr),
    .out_valid(out_valid), .out_msg(out_msg));

  task automatic chk(input string tag, input vec_t act, input vec_t exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int phi_ref(input int i);
    real x, y;
    int r;
    if (i == 0) return 63;
    x = i / 4.0;
    y = $ln(($exp(x) + 1.0) / ($exp(x) - 1.0)) * 4.0;
    r = $rtoi(y + 0.5);
    return (r > 63) ? 63 : r;
  endfunction

  function automatic vec_t model(input vec_t v);
    int m [DEG];
    int p [DEG];
    bit n [DEG];
    int s;
    vec_t o;
    s = 0;
    for (int k = 0; k < DEG; k++) begin
      int a;
      a = $signed(v[k*W +: W]);
      n[k] = (a < 0);
      m[k] = n[k] ? -a : a;
      if (m[k] > 63) m[k] = 63;
      p[k] = phi_ref(m[k]);
      s += p[k];
    end
    for (int k = 0; k < DEG; k++) begin
      int e, mag, negs, val;
      e = s - p[k];
      if (e > 63) e = 63;
      mag = phi_ref(e);
      negs = 0;
      for (int j = 0; j < DEG; j++) if (j != k && n[j]) negs++;
      val = (negs % 2 == 1) ? -mag : mag;
      o[k*W +: W] = W'(val);
    end
    return o;
  endfunction

  function automatic vec_t rnd_row();
    vec_t v;
    for (int k = 0; k < DEG; k++) begin
      int r, a;
      r = $urandom_range(0, 99);
      if (r < 5)       a = -128;
      else if (r < 20) a = $urandom_range(12, 127);
      else             a = $urandom_range(0, 11);
      if (a != -128 && $urandom_range(0, 1) == 1) a = -a;
      v[k*W +: W] = W'(a);
    end
    return v;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    vec_t last;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_llr   = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset out_valid", vec_t'(out_valid), '0);
    chk("R1 reset out_msg", out_msg, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NTAB; i++) begin
      sv[i] = STIM[i];
      ev[i] = EXPV[i];
      // R3 R4: model agrees with the hand-worked rows
      chk("R3 R4 model vs hand row", model(STIM[i]), EXPV[i]);
    end
    for (int i = NTAB; i < NALL; i++) begin
      sv[i] = rnd_row();
      ev[i] = model(sv[i]);
    end

    // R6: back-to-back stream; R2 R3 R4 R5 per row at 3-cycle latency (R1)
    for (int c = 0; c < NALL + 3; c++) begin
      if (c >= 3) begin
        chk("R1 R6 out_valid in stream", vec_t'(out_valid), vec_t'(1));
        chk((c - 3 < NTAB) ? "R2 R3 R4 R5 table row" : "R3 R4 R6 random row",
            out_msg, ev[c-3]);
      end
      if (c < NALL) begin
        in_valid = 1'b1;
        in_llr   = sv[c];
      end else begin
        in_valid = 1'b0;
        in_llr   = rnd_row();
      end
      @(negedge clk);
    end
    chk("R1 out_valid after drain", vec_t'(out_valid), '0);
    last = out_msg;

    // R7: garbage with in_valid low has no effect
    for (int c = 0; c < 5; c++) begin
      in_llr = rnd_row();
      @(negedge clk);
      chk("R7 idle out_valid", vec_t'(out_valid), '0);
      chk("R7 idle out_msg held", out_msg, last);
    end

    // R6 R7: valid, invalid garbage, valid
    in_valid = 1'b1; in_llr = STIM[3];
    @(negedge clk);
    in_valid = 1'b0; in_llr = 32'h01010101;
    @(negedge clk);
    in_valid = 1'b1; in_llr = STIM[6];
    @(negedge clk);
    in_valid = 1'b0; in_llr = 32'h7F7F7F7F;
    chk("R6 gap first row", out_msg, EXPV[3]);
    chk("R6 gap first valid", vec_t'(out_valid), vec_t'(1));
    @(negedge clk);
    chk("R7 gap out_valid low", vec_t'(out_valid), '0);
    chk("R7 gap out_msg held", out_msg, EXPV[3]);
    @(negedge clk);
    chk("R6 gap second row", out_msg, EXPV[6]);
    @(negedge clk);

    // R1: reset in mid-flight clears the pipeline
    in_valid = 1'b1; in_llr = STIM[4];
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid reset out_msg", out_msg, '0);
    rst_n = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk("R1 no output after reset", vec_t'(out_valid), '0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule